// File: doc/BRIEF.md
# Block Erase Engine with Suspend and Nested Program

This block sequences a timed block erase for a flash device and lets the host pause it through command writes on a simple strobed bus. While the erase is paused, the block allows a short program operation to run. That program can itself be paused and continued. A request to restart the erase that arrives while such a program is active or paused is recorded. The erase restarts only when the program has finished. The durations of both operations are modelled by cycle counters. The erase counter keeps its value across a pause, so a paused and restarted erase runs for the same number of active cycles as one that was never paused.

The host watches an 8-bit status word and a single status pin. The status word holds a ready flag, an erase-paused flag, an erase-error flag and a program-paused flag. While the erase is paused, the block accepts only a small set of commands. Any other command code leaves the state and the read mode unchanged. The program-enable input must stay high for the whole pause. If it falls at any point, the restart request ends the erase with an error instead of continuing it.

Top module: `fsr_erase_suspend_ctrl`

## Requirements
- R1: The erase command (code 0x20), issued while idle, clears status bit 7. Bit 7 stays clear until the erase counter has seen ERASE_CYCLES active cycles, and then returns to 1. In level mode the status pin follows bit 7, so it is low while busy.
- R2: The suspend command (0xB0) during an erase sets status bits 7 and 6 from the next cycle and freezes the erase counter. The same command has no effect on the state or the read mode when no erase is running.
- R3: The erase resume command (0xD0) restarts a paused erase from its frozen count, and clears status bits 7 and 6. The total number of active erase cycles, summed over every pause, equals ERASE_CYCLES.
- R4: While the erase is paused, only read-status (0x70), clear-status (0x50), query (0x98), configure (0xB8), erase resume (0xD0) and program (0x40) are accepted. Any other code, including read-array (0xFF), erase (0x20) and program resume (0xD1), leaves the status word and the read mode unchanged.
- R5: A program issued during the pause runs for PROG_CYCLES active cycles with status 0x40 (bit 7 clear, bit 6 set). Without a pending resume, the block then returns to the paused state with status 0xC0.
- R6: The suspend command during a nested program pauses it, giving status 0xC4 (bit 2 set). The program resume command (0xD1) continues the program from where it stopped.
- R7: An erase resume that arrives while a nested program is running or paused is held. The erase restarts on the cycle after that program completes, and never before.
- R8: If the program-enable input is low on any cycle of the pause, including the resume cycle, the resume aborts the erase: status becomes 0xA0 (bit 5 set, idle). Clear-status clears bit 5. A later erase then runs for the full ERASE_CYCLES.
- R9: After an accepted resume or suspend command, the read mode output is 1 (status data). Query sets it to 2 and read-array sets it to 0, whenever those commands are accepted.
- R10: Configure with cmd_arg=1 selects pulse mode. In pulse mode the status pin stays high except for one cycle, following each completion of an erase or a program, when it is low. Configure with cmd_arg=0 restores level mode.
- R11: After reset the status word is 0x80, the status pin is high and the read mode is 0 (array).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| cmd_arg | input | 1 | Argument of the configure command (status pin mode) |
| pen_ok | input | 1 | Program-enable level, high when programming and erasing are allowed |
| status | output | 8 | Status word: bit 7 ready, bit 6 erase paused, bit 5 erase error, bit 2 program paused |
| sts | output | 1 | Status pin |
| rd_mode | output | 2 | Data the bus returns on reads: 0 array, 1 status, 2 query |

## Verification
The assertions assume that a command strobe lasts one cycle and carries a single code. They also assume that the host sends a suspend only while the targeted operation has at least one more active cycle to run, so that the pause and the completion never fall on the same edge. The random stimulus tracks the active erase and program cycles it has seen from the status word, and sends a suspend only while the remaining count leaves a margin. Resume requests are placed at random points, both inside and outside a nested program. The program-enable input is held high except in the directed abort cases.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam logic [7:0] OP_ERASE = 8'h20;
    localparam logic [7:0] OP_PROG  = 8'h40;
    localparam logic [7:0] OP_SUSP  = 8'hB0;
    localparam logic [7:0] OP_ERES  = 8'hD0;
    localparam logic [7:0] OP_PRES  = 8'hD1;
    localparam logic [7:0] OP_RSTAT = 8'h70;
    localparam logic [7:0] OP_CLR   = 8'h50;
    localparam logic [7:0] OP_QRY   = 8'h98;
    localparam logic [7:0] OP_CFG   = 8'hB8;
    localparam logic [7:0] OP_RARR  = 8'hFF;

    localparam int unsigned SB_READY = 7;
    localparam int unsigned SB_ESUSP = 6;
    localparam int unsigned SB_EERR  = 5;
    localparam int unsigned SB_PSUSP = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_ESUSP,
        ST_ESUSP_PROG,
        ST_ESUSP_PSUSP
    } ctl_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_QUERY  = 2'd2
    } rd_mode_e;

    typedef struct packed {
        logic erase;
        logic prog;
        logic susp;
        logic eres;
        logic pres;
        logic rstat;
        logic clr;
        logic qry;
        logic cfg;
        logic rarr;
    } cmd_strb_t;

    function automatic cmd_strb_t decode_cmd(input logic [7:0] c);
        cmd_strb_t d;
        d.erase = (c == OP_ERASE);
        d.prog  = (c == OP_PROG);
        d.susp  = (c == OP_SUSP);
        d.eres  = (c == OP_ERES);
        d.pres  = (c == OP_PRES);
        d.rstat = (c == OP_RSTAT);
        d.clr   = (c == OP_CLR);
        d.qry   = (c == OP_QRY);
        d.cfg   = (c == OP_CFG);
        d.rarr  = (c == OP_RARR);
        return d;
    endfunction

    function automatic cmd_strb_t permitted(input ctl_state_e st);
        cmd_strb_t m;
        m = '0;
        m.rstat = 1'b1;
        case (st)
            ST_IDLE: begin
                m.erase = 1'b1; m.prog = 1'b1; m.clr = 1'b1;
                m.qry = 1'b1; m.cfg = 1'b1; m.rarr = 1'b1;
            end
            ST_ERASE: m.susp = 1'b1;
            ST_ESUSP: begin
                m.qry = 1'b1; m.clr = 1'b1; m.cfg = 1'b1;
                m.eres = 1'b1; m.prog = 1'b1;
            end
            ST_ESUSP_PROG: begin
                m.susp = 1'b1; m.eres = 1'b1;
            end
            ST_ESUSP_PSUSP: begin
                m.pres = 1'b1; m.eres = 1'b1; m.qry = 1'b1;
                m.clr = 1'b1; m.cfg = 1'b1;
            end
            default: ;
        endcase
        return m;
    endfunction

    function automatic logic in_erase_pause(input ctl_state_e st);
        return (st == ST_ESUSP) || (st == ST_ESUSP_PROG) || (st == ST_ESUSP_PSUSP);
    endfunction

endpackage

// File: rtl/fsr_cmd_filter.sv
module fsr_cmd_filter
    import fsr_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  ctl_state_e st,
    output cmd_strb_t  strb,
    output logic       rejected
);
    cmd_strb_t raw;

    always_comb begin
        raw      = decode_cmd(cmd_code);
        strb     = cmd_valid ? cmd_strb_t'(raw & permitted(st)) : '0;
        rejected = cmd_valid && (strb == '0);
    end
endmodule

// File: rtl/fsr_op_timer.sv
module fsr_op_timer #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    input  logic clear,
    output logic done
);
    localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (run && active) begin
            if (cnt == LAST) begin
                cnt    <= '0;
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb done = active && run && (cnt == LAST);

    // R3
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !start && !clear) |=> $stable(cnt));

    // R1
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> (cnt == '0));
endmodule

// File: rtl/fsr_status_out.sv
module fsr_status_out
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_state_e st,
    input  logic       err,
    input  logic       pulse_mode,
    input  logic       op_done,
    output logic [7:0] status,
    output logic       sts
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= op_done;
    end

    always_comb begin
        status            = '0;
        status[SB_READY]  = (st == ST_IDLE) || (st == ST_ESUSP) || (st == ST_ESUSP_PSUSP);
        status[SB_ESUSP]  = in_erase_pause(st);
        status[SB_EERR]   = err;
        status[SB_PSUSP]  = (st == ST_ESUSP_PSUSP);
        sts               = pulse_mode ? !done_q : status[SB_READY];
    end

    // R10
    pulse_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && op_done) |=> !sts);

    // R10
    pulse_high_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && !op_done) |=> sts);
endmodule

// File: rtl/fsr_erase_suspend_ctrl.sv
module fsr_erase_suspend_ctrl
    import fsr_pkg::*;
#(
    parameter int unsigned ERASE_CYCLES = 64,
    parameter int unsigned PROG_CYCLES  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       cmd_arg,
    input  logic       pen_ok,
    output logic [7:0] status,
    output logic       sts,
    output logic [1:0] rd_mode
);
    ctl_state_e st, st_n;
    rd_mode_e   rm, rm_n;
    logic       pend, pend_n;
    logic       lost, lost_n;
    logic       err, err_n;
    logic       pmode, pmode_n;
    logic       e_start, e_clear, e_done;
    logic       p_start, p_done;
    logic       resume_take;
    logic       rej;
    cmd_strb_t  s;

    fsr_cmd_filter u_filter (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .st        (st),
        .strb      (s),
        .rejected  (rej)
    );

    fsr_op_timer #(.LEN(ERASE_CYCLES)) u_erase_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (e_start),
        .run   (st == ST_ERASE),
        .clear (e_clear),
        .done  (e_done)
    );

    fsr_op_timer #(.LEN(PROG_CYCLES)) u_prog_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (p_start),
        .run   ((st == ST_PROG) || (st == ST_ESUSP_PROG)),
        .clear (1'b0),
        .done  (p_done)
    );

    fsr_status_out u_status (
        .clk        (clk),
        .rst        (rst),
        .st         (st),
        .err        (err),
        .pulse_mode (pmode),
        .op_done    (e_done || p_done),
        .status     (status),
        .sts        (sts)
    );

    always_comb begin
        st_n        = st;
        rm_n        = rm;
        pend_n      = pend;
        lost_n      = lost;
        err_n       = err;
        pmode_n     = pmode;
        e_start     = 1'b0;
        e_clear     = 1'b0;
        p_start     = 1'b0;
        resume_take = 1'b0;

        if (in_erase_pause(st) && !pen_ok) lost_n = 1'b1;

        case (st)
            ST_IDLE: begin
                if (s.erase) begin
                    st_n    = ST_ERASE;
                    e_start = 1'b1;
                end else if (s.prog) begin
                    st_n    = ST_PROG;
                    p_start = 1'b1;
                end
            end
            ST_PROG: begin
                if (p_done) st_n = ST_IDLE;
            end
            ST_ERASE: begin
                if (e_done) begin
                    st_n = ST_IDLE;
                end else if (s.susp) begin
                    st_n   = ST_ESUSP;
                    lost_n = 1'b0;
                end
            end
            ST_ESUSP: begin
                if (s.prog) begin
                    st_n    = ST_ESUSP_PROG;
                    p_start = 1'b1;
                end else if (s.eres) begin
                    resume_take = 1'b1;
                end
            end
            ST_ESUSP_PROG: begin
                if (p_done) begin
                    if (pend || s.eres) resume_take = 1'b1;
                    else                st_n = ST_ESUSP;
                end else begin
                    if (s.susp) st_n = ST_ESUSP_PSUSP;
                    if (s.eres) pend_n = 1'b1;
                end
            end
            ST_ESUSP_PSUSP: begin
                if (s.pres) st_n = ST_ESUSP_PROG;
                if (s.eres) pend_n = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase

        if (resume_take) begin
            pend_n = 1'b0;
            if (lost || !pen_ok) begin
                err_n   = 1'b1;
                st_n    = ST_IDLE;
                e_clear = 1'b1;
            end else begin
                st_n = ST_ERASE;
            end
        end

        if (s.erase || s.prog || s.susp || s.eres || s.pres || s.rstat) rm_n = RM_STATUS;
        if (s.qry)  rm_n = RM_QUERY;
        if (s.rarr) rm_n = RM_ARRAY;
        if (s.clr)  err_n = 1'b0;
        if (s.cfg)  pmode_n = cmd_arg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            rm    <= RM_ARRAY;
            pend  <= 1'b0;
            lost  <= 1'b0;
            err   <= 1'b0;
            pmode <= 1'b0;
        end else begin
            st    <= st_n;
            rm    <= rm_n;
            pend  <= pend_n;
            lost  <= lost_n;
            err   <= err_n;
            pmode <= pmode_n;
        end
    end

    always_comb rd_mode = rm;

    // R2
    susp_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERASE && s.susp && !e_done) |=> (status[SB_READY] && status[SB_ESUSP]));

    // R2
    idle_susp_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cmd_valid && cmd_code == OP_SUSP) |=> (st == ST_IDLE && $stable(rm)));

    // R4
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (in_erase_pause(st) && rej && !p_done) |=> ($stable(st) && $stable(rm)));

    // R7
    hold_resume_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ESUSP_PROG || st == ST_ESUSP_PSUSP) && !p_done) |=> (st != ST_ERASE));

    // R3
    resume_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (resume_take && !lost && pen_ok) |=> (!status[SB_READY] && !status[SB_ESUSP]));

    // R8
    pen_err_chk: assert property (@(posedge clk) disable iff (rst)
        (resume_take && (lost || !pen_ok)) |=> (status[SB_EERR] && st == ST_IDLE));

    // R9
    resume_read_chk: assert property (@(posedge clk) disable iff (rst)
        (s.eres || s.pres) |=> (rm == RM_STATUS));
endmodule

// File: tb/tb_fsr_erase_suspend_ctrl.sv
`timescale 1ns/1ps
module tb_fsr_erase_suspend_ctrl;
    import fsr_pkg::*;

    localparam int ELEN = 24;
    localparam int PLEN = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       cmd_arg = 1'b0;
    logic       pen_ok = 1'b1;
    logic [7:0] status;
    logic       sts;
    logic [1:0] rd_mode;

    int n_tests = 0;
    int n_fail  = 0;
    int eb = 0, pb_total = 0, pb_cur = 0, nprog = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fsr_erase_suspend_ctrl #(.ERASE_CYCLES(ELEN), .PROG_CYCLES(PLEN)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .pen_ok(pen_ok), .status(status), .sts(sts), .rd_mode(rd_mode)
    );

    function automatic logic [7:0] exp_stat(input bit rdy, input bit esus, input bit eerr, input bit psus);
        logic [7:0] v;
        v = 8'h00;
        v[7] = rdy; v[6] = esus; v[5] = eerr; v[2] = psus;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (status[7] == 1'b0 && status[6] == 1'b0) eb++;
        if (status[7] == 1'b0 && status[6] == 1'b1) begin pb_total++; pb_cur++; end
    endtask

    task automatic send(input logic [7:0] c, input logic a);
        cmd_code  = c;
        cmd_arg   = a;
        cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic random_trial();
        int  guard;
        bit  eres_sent;
        eb = 0; pb_total = 0; nprog = 0; guard = 0;
        send(OP_ERASE, 1'b0);
        chk("R1 busy status", status, exp_stat(0, 0, 0, 0));
        chk("R1 pin low", sts, 0);
        while (!(status[7] && !status[6]) && guard < 4000) begin
            guard++;
            if (eb < ELEN - 1 && ($urandom % 5) == 0) begin
                send(OP_SUSP, 1'b0);
                chk("R2 paused status", status, exp_stat(1, 1, 0, 0));
                chk("R2 pin high", sts, 1);
                repeat ($urandom % 3) tick();
                chk("R2 stays paused", status, exp_stat(1, 1, 0, 0));
                eres_sent = 1'b0;
                if ($urandom % 2) begin
                    pb_cur = 0;
                    nprog++;
                    send(OP_PROG, 1'b0);
                    chk("R5 nested program status", status, exp_stat(0, 1, 0, 0));
                    if ($urandom % 3 == 0) begin
                        send(OP_ERES, 1'b0);
                        eres_sent = 1'b1;
                    end
                    if (status == exp_stat(0, 1, 0, 0) && pb_cur < PLEN - 1 && ($urandom % 2)) begin
                        send(OP_SUSP, 1'b0);
                        chk("R6 program paused", status, exp_stat(1, 1, 0, 1));
                        repeat ($urandom % 3) tick();
                        if (!eres_sent && ($urandom % 2)) begin
                            send(OP_ERES, 1'b0);
                            eres_sent = 1'b1;
                            chk("R7 resume held", status, exp_stat(1, 1, 0, 1));
                        end
                        send(OP_PRES, 1'b0);
                        chk("R6 program continues", status, exp_stat(0, 1, 0, 0));
                    end
                    while (status == exp_stat(0, 1, 0, 0) && guard < 4000) begin
                        guard++;
                        tick();
                    end
                    chk("R5 program length", pb_cur, PLEN);
                    if (eres_sent) chk("R7 erase after program", status, exp_stat(0, 0, 0, 0));
                    else           chk("R5 back to paused", status, exp_stat(1, 1, 0, 0));
                end
                if (!eres_sent) begin
                    send(OP_ERES, 1'b0);
                    chk("R3 resume clears flags", status, exp_stat(0, 0, 0, 0));
                    chk("R3 pin low", sts, 0);
                    chk("R9 status read mode", rd_mode, 1);
                end
            end else begin
                tick();
            end
        end
        chk("R3 total erase cycles", eb, ELEN);
        chk("R5 total program cycles", pb_total, nprog * PLEN);
        chk("R1 ready pin", sts, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL WDOG: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 status", status, 8'h80);
        chk("R11 pin", sts, 1);
        chk("R11 read mode", rd_mode, 0);

        // R2 suspend while idle does nothing
        send(OP_SUSP, 1'b0);
        chk("R2 idle suspend status", status, 8'h80);
        chk("R2 idle suspend mode", rd_mode, 0);
        send(OP_ERES, 1'b0);
        chk("R2 idle resume mode", rd_mode, 0);

        // R1 plain erase length
        eb = 0;
        send(OP_ERASE, 1'b0);
        while (!status[7]) tick();
        chk("R1 erase length", eb, ELEN);
        chk("R9 after erase", rd_mode, 1);

        // R4 command filter during pause
        send(OP_ERASE, 1'b0);
        tick();
        send(OP_SUSP, 1'b0);
        send(OP_QRY, 1'b0);
        chk("R9 query accepted", rd_mode, 2);
        send(OP_RARR, 1'b0);
        chk("R4 read-array ignored", rd_mode, 2);
        send(OP_ERASE, 1'b0);
        chk("R4 erase ignored mode", rd_mode, 2);
        chk("R4 erase ignored status", status, exp_stat(1, 1, 0, 0));
        send(OP_PRES, 1'b0);
        chk("R4 program resume ignored", rd_mode, 2);
        send(OP_RSTAT, 1'b0);
        chk("R4 read status accepted", rd_mode, 1);
        send(OP_ERES, 1'b0);
        while (!status[7]) tick();
        chk("R4 erase completes", status, 8'h80);

        // R8 program-enable drop during pause
        send(OP_ERASE, 1'b0);
        repeat (3) tick();
        send(OP_SUSP, 1'b0);
        pen_ok = 1'b0;
        repeat (2) tick();
        pen_ok = 1'b1;
        tick();
        send(OP_ERES, 1'b0);
        chk("R8 abort status", status, exp_stat(1, 0, 1, 0));
        send(OP_CLR, 1'b0);
        chk("R8 cleared", status, 8'h80);
        eb = 0;
        send(OP_ERASE, 1'b0);
        while (!status[7]) tick();
        chk("R8 fresh erase length", eb, ELEN);

        // R8 enable low only on the resume cycle
        send(OP_ERASE, 1'b0);
        send(OP_SUSP, 1'b0);
        pen_ok = 1'b0;
        send(OP_ERES, 1'b0);
        pen_ok = 1'b1;
        chk("R8 late drop abort", status, exp_stat(1, 0, 1, 0));
        send(OP_CLR, 1'b0);

        // R10 pulse mode on the status pin
        send(OP_CFG, 1'b1);
        chk("R10 pulse idle high", sts, 1);
        send(OP_PROG, 1'b0);
        for (int i = 0; i < PLEN; i++) begin
            chk("R10 pin high while busy", {status[7], sts}, 2'b01);
            if (i < PLEN - 1) tick();
        end
        tick();
        chk("R10 ready after program", status, 8'h80);
        chk("R10 pulse low", sts, 0);
        tick();
        chk("R10 pulse ends", sts, 1);
        send(OP_CFG, 1'b0);
        chk("R10 level mode restored", sts, 1);

        // random trials mixing pauses, nested programs and resume points
        for (int t = 0; t < 25; t++) random_trial();

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule